// File: doc/BRIEF.md
# Scatter-Gather Descriptor Cache

This block sits between a two-channel scatter-gather DMA engine and system memory. It keeps a small circular store of 128-bit buffer descriptors for each channel, so the engine can begin its next transfer without a round trip to memory. Each store has a read pointer and a write pointer. The block asks memory for descriptors through a request port, two descriptors per request. Returned descriptors arrive one per beat, tagged with the channel they belong to. The descriptor at the head of each store is shown to the engine, and the engine removes it with a take strobe.

Memory can return three kinds of descriptor. A data descriptor is cached and the channel runs on. A jump descriptor redirects fetching to a new address once the cache has drained. An invalid descriptor marks the end of the available list. The channel then waits for software to signal, through a per-channel resume strobe, that more descriptors have been written. Refills during normal running are paced by a programmable occupancy threshold. When channels compete for the request port, they are served in ascending order from a snapshot of the pending set.

Top module: `dma_desc_cache`

## Requirements
- R1: After reset no fetch request is raised and no channel shows a valid head descriptor.
- R2: When a channel's enable input goes high, that channel requests a two-descriptor block at its start address, and the request carries the channel number.
- R3: While running normally, a channel requests a block whenever its occupancy (write pointer minus read pointer) is at or below the refill threshold, and never while the occupancy is above it. Each normal block moves that channel's next fetch address on by 32 bytes.
- R4: A returned descriptor that finds its channel's store full (occupancy equal to the depth) is discarded. Descriptors leave each store in the order they were written.
- R5: Bits [1:0] of a descriptor give its kind: 01 is data, 10 is jump, and 00 and 11 are invalid. Only data and jump descriptors are ever written into a store.
- R6: A jump descriptor is cached if there is room, and its bits [127:64] are kept as the next fetch address. The rest of its block is dropped. Threshold refills stop for that channel, and once its store is empty it requests a block at the jump address.
- R7: An invalid descriptor and the rest of its block are dropped. The channel then requests nothing until its store is empty and a resume strobe has been seen while it waits. It then fetches the same block address again. A resume strobe given while the channel is running normally has no effect.
- R8: A channel has at most one outstanding request. A request is complete after two response beats, and each beat is routed by its channel number only.
- R9: Pending channels are served one request each in ascending channel order. A new snapshot of pending channels is taken only after the previous one has been served.
- R10: A channel's head descriptor stays valid and unchanged until the engine takes it. A take removes exactly one entry.
- R11: A raised fetch request holds its channel and address unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | NCH | Per-channel enable; a rising level starts the channel |
| start_addr | input | NCH*AW | Per-channel first fetch address |
| refill_lvl | input | PW | Occupancy at or below which a running channel refills |
| resume | input | NCH | Per-channel software resume strobe |
| fetch_valid | output | 1 | Fetch request raised |
| fetch_ready | input | 1 | Fetch request accepted |
| fetch_chan | output | CW | Channel of the request |
| fetch_addr | output | AW | Byte address of the two-descriptor block |
| cpl_valid | input | 1 | Response beat present |
| cpl_chan | input | CW | Channel the beat belongs to |
| cpl_desc | input | DW | Returned descriptor |
| head_valid | output | NCH | Per-channel head descriptor present |
| head_desc | output | NCH*DW | Per-channel head descriptor |
| head_take | input | NCH | Per-channel consume strobe |

## Verification
The timing of every result is fixed. A take or a stored beat shows at the head one clock edge later. A new request condition, such as enable, a drained store or resume, raises `fetch_valid` within two edges: one to settle the channel's state and one to load the arbiter snapshot. The bench therefore reads head outputs one cycle after each beat or take, polls for requests over a bounded window of eight cycles, and tests for the absence of a request over three or four cycles, which is longer than that latency. All sampling happens one time unit after the active edge.

// File: rtl/dma_desc_cache.sv
module dma_desc_cache #(
  parameter int NCH   = 2,
  parameter int DEPTH = 2,
  parameter int AW    = 64,
  parameter int DW    = 128,
  localparam int PW   = $clog2(DEPTH) + 1,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chan_en,
  input  logic [NCH*AW-1:0] start_addr,
  input  logic [PW-1:0]     refill_lvl,
  input  logic [NCH-1:0]    resume,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [CW-1:0]     fetch_chan,
  output logic [AW-1:0]     fetch_addr,
  input  logic              cpl_valid,
  input  logic [CW-1:0]     cpl_chan,
  input  logic [DW-1:0]     cpl_desc,
  output logic [NCH-1:0]    head_valid,
  output logic [NCH*DW-1:0] head_desc,
  input  logic [NCH-1:0]    head_take
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_JUMP, S_HOLD} st_t;

  st_t            st   [NCH];
  logic [PW-1:0]  wp   [NCH];
  logic [PW-1:0]  rp   [NCH];
  logic [AW-1:0]  nxt  [NCH];
  logic [AW-1:0]  jad  [NCH];
  logic [DW-1:0]  mem  [NCH][DEPTH];
  logic [NCH-1:0] busy, beat, rflag, want, snap, pend, gnt;
  logic [NCH*PW-1:0] occ;
  logic [CW-1:0]  sel;
  logic           fire;

  wire [1:0] ty   = cpl_desc[1:0];
  wire       good = (ty == 2'b01) || (ty == 2'b10);

  assign pend        = snap & want;
  assign fetch_valid = |pend;
  assign fire        = fetch_valid && fetch_ready;

  always_comb begin
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (pend[i]) sel = CW'(i);
  end

  assign gnt        = fire ? (NCH'(1) << sel) : '0;
  assign fetch_chan = sel;
  assign fetch_addr = (st[sel] == S_JUMP) ? jad[sel] : nxt[sel];

  always_ff @(posedge clk) begin
    if (!rst_n)                snap <= '0;
    else if (fire)             snap <= pend & ~gnt;
    else if (pend == '0)       snap <= want;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire [PW-1:0] cnt   = wp[c] - rp[c];
    wire          hit   = cpl_valid && (cpl_chan == CW'(c));
    wire          full  = (cnt == PW'(DEPTH));
    wire          store = hit && (st[c] == S_RUN) && good && !full;
    wire          take  = head_valid[c] && head_take[c];

    assign occ[c*PW +: PW]       = cnt;
    assign head_valid[c]         = (cnt != '0);
    assign head_desc[c*DW +: DW] = mem[c][rp[c][IW-1:0]];

    always_comb begin
      case (st[c])
        S_RUN:   want[c] = !busy[c] && (cnt <= refill_lvl);
        S_JUMP:  want[c] = !busy[c] && (cnt == '0);
        S_HOLD:  want[c] = !busy[c] && (cnt == '0) && rflag[c];
        default: want[c] = 1'b0;
      endcase
    end

    always_ff @(posedge clk)
      if (store) mem[c][wp[c][IW-1:0]] <= cpl_desc;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st[c]    <= S_IDLE;
        wp[c]    <= '0;
        rp[c]    <= '0;
        nxt[c]   <= '0;
        jad[c]   <= '0;
        busy[c]  <= 1'b0;
        beat[c]  <= 1'b0;
        rflag[c] <= 1'b0;
      end else begin
        if (take)  rp[c] <= rp[c] + 1'b1;
        if (store) wp[c] <= wp[c] + 1'b1;
        case (st[c])
          S_IDLE: if (chan_en[c]) begin
            st[c]  <= S_RUN;
            nxt[c] <= start_addr[c*AW +: AW];
          end
          S_RUN: if (hit) begin
            if (ty == 2'b10) begin
              st[c]  <= S_JUMP;
              jad[c] <= cpl_desc[DW-1 -: AW];
            end else if (!good) begin
              st[c] <= S_HOLD;
            end
          end
          S_JUMP: if (gnt[c]) begin
            st[c]  <= S_RUN;
            nxt[c] <= jad[c];
          end
          default: begin
            if (resume[c]) rflag[c] <= 1'b1;
            if (gnt[c]) begin
              st[c]    <= S_RUN;
              rflag[c] <= 1'b0;
            end
          end
        endcase
        if (gnt[c]) begin
          busy[c] <= 1'b1;
          beat[c] <= 1'b0;
        end else if (hit) begin
          beat[c] <= ~beat[c];
          if (beat[c]) begin
            busy[c] <= 1'b0;
            if (st[c] == S_RUN && ty == 2'b01) nxt[c] <= nxt[c] + AW'(32);
          end
        end
      end
    end
  end
endmodule

module dma_desc_cache_chk #(
  parameter int NCH = 2,
  parameter int DEPTH = 2,
  parameter int AW = 64,
  parameter int DW = 128,
  parameter int PW = 2,
  parameter int CW = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic [CW-1:0]     fetch_chan,
  input logic [AW-1:0]     fetch_addr,
  input logic              cpl_valid,
  input logic [CW-1:0]     cpl_chan,
  input logic [NCH-1:0]    head_valid,
  input logic [NCH*DW-1:0] head_desc,
  input logic [NCH-1:0]    head_take,
  input logic [NCH*PW-1:0] occ
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_chan) && $stable(fetch_addr)); // R11

  for (genvar c = 0; c < NCH; c++) begin : g_ck
    logic [2:0] ob;
    wire req_c = fetch_valid && fetch_ready && (fetch_chan == CW'(c));
    wire cpl_c = cpl_valid && (cpl_chan == CW'(c));

    always_ff @(posedge clk)
      if (!rst_n) ob <= '0;
      else        ob <= ob + (req_c ? 3'd2 : 3'd0) - (cpl_c ? 3'd1 : 3'd0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      occ[c*PW +: PW] <= PW'(DEPTH)); // R4
    AST_STORED_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      head_valid[c] |-> (head_desc[c*DW +: 2] == 2'b01 || head_desc[c*DW +: 2] == 2'b10)); // R5
    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      head_valid[c] && !head_take[c] |=> head_valid[c] && $stable(head_desc[c*DW +: DW])); // R10
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid && (fetch_chan == CW'(c)) |-> ob == 3'd0); // R8
  end
endmodule

bind dma_desc_cache dma_desc_cache_chk #(
  .NCH(NCH), .DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
  .fetch_chan(fetch_chan), .fetch_addr(fetch_addr), .cpl_valid(cpl_valid),
  .cpl_chan(cpl_chan), .head_valid(head_valid), .head_desc(head_desc),
  .head_take(head_take), .occ(occ)
);

// File: tb/dma_desc_cache_test.sv
`timescale 1ns/100ps
module dma_desc_cache_test;
  localparam logic [63:0] B0 = 64'h0000_0000_0001_0000;
  localparam logic [63:0] B1 = 64'h0000_0000_0002_0000;

  logic clk = 0, rst_n = 0;
  logic [1:0] chan_en = 0, resume = 0, head_take = 0, refill_lvl = 0;
  logic fetch_ready = 0, cpl_valid = 0, cpl_chan = 0;
  logic [127:0] cpl_desc = 0;
  logic fetch_valid, fetch_chan;
  logic [63:0] fetch_addr;
  logic [1:0] head_valid;
  logic [255:0] head_desc;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  dma_desc_cache uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .start_addr({B1, B0}),
    .refill_lvl(refill_lvl), .resume(resume), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_chan(fetch_chan), .fetch_addr(fetch_addr),
    .cpl_valid(cpl_valid), .cpl_chan(cpl_chan), .cpl_desc(cpl_desc),
    .head_valid(head_valid), .head_desc(head_desc), .head_take(head_take)
  );

  function automatic logic [127:0] dd(input logic [31:0] tag);
    return {64'h0, tag, 30'h0, 2'b01};
  endfunction
  function automatic logic [127:0] jd(input logic [63:0] a);
    return {a, 62'h0, 2'b10};
  endfunction

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] t);
    rst_n = 0; chan_en = 0; resume = 0; head_take = 0; fetch_ready = 0;
    cpl_valid = 0; refill_lvl = t;
    repeat (3) tick;
    rst_n = 1;
    tick;
  endtask

  task automatic expect_req(input string r, input int c, input logic [63:0] a);
    bit ok = 0;
    logic [63:0] ch = 0, ad = 0;
    for (int i = 0; i < 8 && !ok; i++) begin
      if (fetch_valid) begin
        ok = 1; ch = 64'(fetch_chan); ad = fetch_addr;
        fetch_ready = 1; tick; fetch_ready = 0;
      end else tick;
    end
    chk(r, 64'(ok), 1);
    if (ok) begin chk(r, ch, 64'(c)); chk(r, ad, a); end
  endtask

  task automatic no_req(input string r, input int n);
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      if (fetch_valid) seen = 1;
      tick;
    end
    chk(r, 64'(seen), 0);
  endtask

  task automatic send(input int c, input logic [127:0] d0, input logic [127:0] d1);
    cpl_valid = 1; cpl_chan = c[0]; cpl_desc = d0; tick;
    cpl_desc = d1; tick;
    cpl_valid = 0; tick;
  endtask

  task automatic take(input int c);
    head_take[c] = 1; tick; head_take = 0;
  endtask

  task automatic head_is(input string r, input int c, input logic [31:0] tag);
    chk(r, 64'(head_valid[c]), 1);
    chk(r, 64'(head_desc[c*128+32 +: 32]), 64'(tag));
  endtask

  task automatic pulse_resume(input int c);
    resume[c] = 1; tick; resume = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] q[$];
    logic [31:0] tg;
    logic [63:0] ad;
    logic [63:0] hc, ha;

    do_reset(0);
    chk("R1 no request", 64'(fetch_valid), 0);
    chk("R1 no head", 64'(head_valid), 0);

    // R3 R4 R10: threshold sweep against an arithmetic model of occupancy
    for (int t = 0; t < 4; t++) begin
      do_reset(t[1:0]);
      q.delete(); tg = 32'd100 * (t + 1); ad = B0;
      chan_en = 2'b01;
      for (int it = 0; it < 10; it++) begin
        if (q.size() <= t) begin
          expect_req(it == 0 ? "R2 prefetch" : "R3 refill", 0, ad);
          send(0, dd(tg), dd(tg + 1));
          for (int k = 0; k < 2; k++) if (q.size() < 2) q.push_back(tg + 32'(k));
          tg += 2; ad += 32;
        end else begin
          no_req("R3 above threshold", 3);
          head_is("R4 R10 order", 0, q[0]);
          take(0); void'(q.pop_front());
        end
      end
      while (q.size() > 0) begin
        head_is("R4 drain", 0, q[0]);
        take(0); void'(q.pop_front());
      end
      chk("R10 empty", 64'(head_valid[0]), 0);
    end

    // R6 jump handling
    do_reset(1);
    chan_en = 2'b01;
    expect_req("R2 start", 0, B0);
    send(0, dd(1), jd(64'h1000));
    no_req("R6 hold", 3);
    head_is("R6 data first", 0, 1);
    take(0);
    no_req("R6 no threshold refill", 4);
    chk("R6 jump cached", 64'(head_desc[1:0]), 2);
    chk("R6 jump addr", head_desc[127:64], 64'h1000);
    take(0);
    expect_req("R6 jump fetch", 0, 64'h1000);
    send(0, jd(64'h2000), dd(2));
    chk("R6 jump stored", 64'(head_desc[1:0]), 2);
    take(0);
    chk("R6 rest dropped", 64'(head_valid[0]), 0);
    expect_req("R6 second jump", 0, 64'h2000);
    send(0, dd(3), dd(4));
    no_req("R3 full", 3);
    head_is("R6 after jump", 0, 3);
    take(0);
    expect_req("R3 advance", 0, 64'h2020);

    // R7 invalid and resume, R5 stored kinds
    do_reset(1);
    chan_en = 2'b10;
    expect_req("R2 chan1", 1, B1);
    send(1, dd(50), 128'h0);
    head_is("R7 before invalid", 1, 50);
    no_req("R7 pending", 3);
    take(1);
    no_req("R7 wait resume", 4);
    pulse_resume(1);
    expect_req("R7 refetch", 1, B1);
    send(1, {126'h7, 2'b11}, dd(51));
    chk("R5 nothing stored", 64'(head_valid[1]), 0);
    no_req("R7 pending again", 3);
    pulse_resume(1);
    expect_req("R7 refetch2", 1, B1);
    send(1, dd(52), dd(53));
    pulse_resume(1);
    no_req("R7 resume ignored", 3);
    head_is("R7 head", 1, 52);
    take(1);
    expect_req("R3 advance chan1", 1, B1 + 64'd32);

    // R9 arbitration, R11 hold, R8 routing
    do_reset(0);
    chan_en = 2'b11;
    for (int i = 0; i < 8 && !fetch_valid; i++) tick;
    hc = 64'(fetch_chan); ha = fetch_addr;
    repeat (3) tick;
    chk("R11 chan hold", 64'(fetch_chan), hc);
    chk("R11 addr hold", fetch_addr, ha);
    chk("R11 still valid", 64'(fetch_valid), 1);
    chk("R9 lowest first", hc, 0);
    expect_req("R9 chan0", 0, B0);
    expect_req("R9 chan1", 1, B1);
    no_req("R8 one outstanding", 4);
    send(1, dd(70), dd(71));
    head_is("R8 routed chan1", 1, 70);
    chk("R8 chan0 untouched", 64'(head_valid[0]), 0);
    send(0, dd(80), dd(81));
    head_is("R8 routed chan0", 0, 80);
    take(1);
    head_is("R10 one removed", 1, 71);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule